// File: doc/BRIEF.md
# Linked Descriptor Chain Fetcher

This block walks a linked list of transfer descriptors held in memory and hands each one, decoded, to a transfer engine. Software supplies the 64-bit address of the first record as two 32-bit halves and pulses a start input. The fetcher reads the 64-byte record one 32-bit word at a time through a simple request/acknowledge read port, splits it into fields and presents them on a valid/ready interface. It then waits for the engine to signal that the transfer is finished.

When the finished descriptor carries the interrupt-request flag, a one-cycle interrupt pulse follows. When it carries the last flag, the fetcher reports end of chain and goes idle. Otherwise it loads the record's next pointer and fetches again. A chain whose final record points back to its head and has the last flag cleared therefore runs forever. The run can be stopped by clearing either of the two enable controls. Each handed-out descriptor carries a sequence tag that counts modulo the burst limit.

Top module: `sgdesc_fetch`

## Requirements
- R1: After reset, busy, rd_req, dsc_valid, irq and chain_end are all low.
- R2: A record is read as 16 words, word i at byte address base+4*i, in increasing order, one word per acknowledge. The request address holds steady while an acknowledge is pending.
- R3: Words are little-endian: word 0 flags, word 1 ID, words 2/3 destination address low/high, 4/5 source address low/high, 6/7 next pointer low/high, 8 row count, 9 row length, 10 source stride, 11 destination stride, 12–15 ignored. The fields appear unchanged on the dsc_* outputs.
- R4: dsc_valid stays high, with stable fields, until dsc_ready. No read is requested while a descriptor is offered or is awaiting xfer_done.
- R5: After xfer_done on a record without the last flag, the next record is fetched from the address in its next-pointer field.
- R6: After xfer_done on a record with flag bit 0 set, chain_end pulses for exactly one cycle and busy is low in that same cycle.
- R7: After xfer_done on a record with flag bit 1 set, irq pulses for exactly one cycle. Records without bit 1 produce no pulse. Other flag bits have no effect.
- R8: A chain with no last flag keeps cycling through its records until it is stopped by an enable.
- R9: start is ignored unless ctl_enable and ctl_sg_enable are both high.
- R10: If an enable is low in the cycle a word is acknowledged, fetching stops after that word: busy falls next cycle and no further word is requested. Enable low while a descriptor awaits xfer_done ends the chain after that completion.
- R11: dsc_tag is 0 for the first record after start and counts each accepted record modulo MAX_BURST (31 by default): 30 is followed by 0.
- R12: The head address is {head_addr_hi, head_addr_lo}, and the upper 32 bits of every record address are used in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_enable | input | 1 | Global enable |
| ctl_sg_enable | input | 1 | Chain mode enable |
| start | input | 1 | Begin a chain at the head address |
| head_addr_lo | input | 32 | Head address, low word |
| head_addr_hi | input | 32 | Head address, high word |
| rd_req | output | 1 | Word read request |
| rd_addr | output | 64 | Word read byte address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| dsc_valid | output | 1 | Descriptor offered |
| dsc_ready | input | 1 | Engine accepts descriptor |
| dsc_id | output | 32 | Transfer ID |
| dsc_dst_addr | output | 64 | Destination address |
| dsc_src_addr | output | 64 | Source address |
| dsc_rows | output | 32 | Row count field |
| dsc_row_len | output | 32 | Row length field |
| dsc_src_stride | output | 32 | Source stride |
| dsc_dst_stride | output | 32 | Destination stride |
| dsc_tag | output | TAG_W | Sequence tag of offered record |
| xfer_done | input | 1 | Engine finished the accepted record |
| busy | output | 1 | Chain in progress |
| irq | output | 1 | Interrupt request pulse |
| chain_end | output | 1 | End-of-chain pulse |

## Verification
Two pairs of events can land in the same cycle. The first pair is an enable drop and a word acknowledge. The bench clears ctl_sg_enable on the very negative edge at which the memory model grants the fourth word. It then expects exactly four words consumed, busy low, and no descriptor offered afterwards. The second pair is a completion that carries both the interrupt and the last flag. It must yield irq and chain_end in the same cycle, with each pulse gone one cycle later. A completion coinciding with a dropped enable on a circular chain is judged by the fetcher going idle instead of following the pointer.

// File: rtl/sgf_pkg.sv
package sgf_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned DESC_WORDS = 16;
    localparam int unsigned KEEP_WORDS = 12;

    localparam int unsigned FLAG_LAST = 0;
    localparam int unsigned FLAG_IRQ  = 1;

    // word positions inside a record
    localparam int unsigned W_FLAGS  = 0;
    localparam int unsigned W_ID     = 1;
    localparam int unsigned W_DST_LO = 2;
    localparam int unsigned W_DST_HI = 3;
    localparam int unsigned W_SRC_LO = 4;
    localparam int unsigned W_SRC_HI = 5;
    localparam int unsigned W_NXT_LO = 6;
    localparam int unsigned W_NXT_HI = 7;
    localparam int unsigned W_ROWS   = 8;
    localparam int unsigned W_ROWLEN = 9;
    localparam int unsigned W_SSTR   = 10;
    localparam int unsigned W_DSTR   = 11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OFFER,
        ST_RUN
    } fsm_e;

    typedef struct packed {
        logic [WORD_W-1:0]   flags;
        logic [WORD_W-1:0]   id;
        logic [2*WORD_W-1:0] dst;
        logic [2*WORD_W-1:0] src;
        logic [2*WORD_W-1:0] nxt;
        logic [WORD_W-1:0]   rows;
        logic [WORD_W-1:0]   rowlen;
        logic [WORD_W-1:0]   sstr;
        logic [WORD_W-1:0]   dstr;
    } desc_t;

endpackage

// File: rtl/sgf_word_addr.sv
module sgf_word_addr #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned OFS_W = IDX_W + 2;

    logic [OFS_W-1:0] ofs;

    assign ofs  = {idx, 2'b00};
    assign addr = base + ADDR_W'(ofs);

endmodule

// File: rtl/sgf_field_store.sv
module sgf_field_store
    import sgf_pkg::*;
#(
    parameter int unsigned NUM_WORDS = KEEP_WORDS,
    parameter int unsigned IDX_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    output desc_t             desc_o
);
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                w_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                w_q <= '0;
            end else begin
                w_q <= w_d;
            end
        end

        assign words[i] = w_q;
    end

    always_comb begin
        desc_o.flags  = words[W_FLAGS];
        desc_o.id     = words[W_ID];
        desc_o.dst    = {words[W_DST_HI], words[W_DST_LO]};
        desc_o.src    = {words[W_SRC_HI], words[W_SRC_LO]};
        desc_o.nxt    = {words[W_NXT_HI], words[W_NXT_LO]};
        desc_o.rows   = words[W_ROWS];
        desc_o.rowlen = words[W_ROWLEN];
        desc_o.sstr   = words[W_SSTR];
        desc_o.dstr   = words[W_DSTR];
    end

endmodule

// File: rtl/sgf_tag_counter.sv
module sgf_tag_counter #(
    parameter int unsigned MAX_COUNT = 31,
    parameter int unsigned W         = $clog2(MAX_COUNT)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] tag
);
    localparam logic [W-1:0] TOP = W'(MAX_COUNT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = (cnt_q == TOP) ? '0 : cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tag = cnt_q;

endmodule

// File: rtl/sgdesc_fetch.sv
module sgdesc_fetch
    import sgf_pkg::*;
#(
    parameter int unsigned MAX_BURST = 31,
    parameter int unsigned TAG_W     = $clog2(MAX_BURST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_enable,
    input  logic              ctl_sg_enable,
    input  logic              start,
    input  logic [31:0]       head_addr_lo,
    input  logic [31:0]       head_addr_hi,
    output logic              rd_req,
    output logic [63:0]       rd_addr,
    input  logic              rd_ack,
    input  logic [31:0]       rd_data,
    output logic              dsc_valid,
    input  logic              dsc_ready,
    output logic [31:0]       dsc_id,
    output logic [63:0]       dsc_dst_addr,
    output logic [63:0]       dsc_src_addr,
    output logic [31:0]       dsc_rows,
    output logic [31:0]       dsc_row_len,
    output logic [31:0]       dsc_src_stride,
    output logic [31:0]       dsc_dst_stride,
    output logic [TAG_W-1:0]  dsc_tag,
    input  logic              xfer_done,
    output logic              busy,
    output logic              irq,
    output logic              chain_end
);
    localparam int unsigned ADDR_W   = 2 * WORD_W;
    localparam int unsigned IDX_W    = $clog2(DESC_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    typedef struct packed {
        fsm_e              st;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  widx;
        logic              irq;
        logic              fin;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    desc_t desc;
    logic  en_all;
    logic  store_we;
    logic  tag_clr;
    logic  tag_inc;
    logic  unused_flag_bits;

    assign en_all           = ctl_enable & ctl_sg_enable;
    assign unused_flag_bits = ^desc.flags;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.irq = 1'b0;
        ctl_d.fin = 1'b0;
        store_we  = 1'b0;
        tag_clr   = 1'b0;
        tag_inc   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start && en_all) begin
                    ctl_d.st   = ST_FETCH;
                    ctl_d.base = {head_addr_hi, head_addr_lo};
                    ctl_d.widx = '0;
                    tag_clr    = 1'b1;
                end
            end
            ST_FETCH: begin
                if (rd_ack) begin
                    store_we = en_all;
                    if (!en_all) begin
                        ctl_d.st = ST_IDLE;
                    end else if (ctl_q.widx == LAST_IDX) begin
                        ctl_d.st = ST_OFFER;
                    end else begin
                        ctl_d.widx = ctl_q.widx + IDX_W'(1);
                    end
                end
            end
            ST_OFFER: begin
                if (!en_all) begin
                    ctl_d.st = ST_IDLE;
                end else if (dsc_ready) begin
                    ctl_d.st = ST_RUN;
                    tag_inc  = 1'b1;
                end
            end
            ST_RUN: begin
                if (xfer_done) begin
                    ctl_d.irq = desc.flags[FLAG_IRQ];
                    if (desc.flags[FLAG_LAST]) begin
                        ctl_d.fin = 1'b1;
                        ctl_d.st  = ST_IDLE;
                    end else if (!en_all) begin
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.st   = ST_FETCH;
                        ctl_d.base = desc.nxt;
                        ctl_d.widx = '0;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, base: '0, widx: '0, irq: 1'b0, fin: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sgf_word_addr #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_addr (
        .base (ctl_q.base),
        .idx  (ctl_q.widx),
        .addr (rd_addr)
    );

    sgf_field_store #(
        .NUM_WORDS (KEEP_WORDS),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_we),
        .wr_idx  (ctl_q.widx),
        .wr_data (rd_data),
        .desc_o  (desc)
    );

    sgf_tag_counter #(
        .MAX_COUNT (MAX_BURST),
        .W         (TAG_W)
    ) u_tag (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tag_clr),
        .inc   (tag_inc),
        .tag   (dsc_tag)
    );

    assign rd_req         = (ctl_q.st == ST_FETCH);
    assign dsc_valid      = (ctl_q.st == ST_OFFER);
    assign busy           = (ctl_q.st != ST_IDLE);
    assign irq            = ctl_q.irq;
    assign chain_end      = ctl_q.fin;
    assign dsc_id         = desc.id;
    assign dsc_dst_addr   = desc.dst;
    assign dsc_src_addr   = desc.src;
    assign dsc_rows       = desc.rows;
    assign dsc_row_len    = desc.rowlen;
    assign dsc_src_stride = desc.sstr;
    assign dsc_dst_stride = desc.dstr;

endmodule

// File: rtl/sgf_fetch_chk.sv
module sgf_fetch_chk #(
    parameter int unsigned MAX_BURST = 31,
    parameter int unsigned TAG_W     = $clog2(MAX_BURST)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_enable,
    input logic             ctl_sg_enable,
    input logic             rd_req,
    input logic [63:0]      rd_addr,
    input logic             rd_ack,
    input logic             dsc_valid,
    input logic             dsc_ready,
    input logic [31:0]      dsc_id,
    input logic [63:0]      dsc_src_addr,
    input logic [TAG_W-1:0] dsc_tag,
    input logic             busy,
    input logic             irq,
    input logic             chain_end
);
    logic en_all;
    assign en_all = ctl_enable & ctl_sg_enable;

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && en_all) |=> (rd_req && $stable(rd_addr)));

    assert_offer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && !dsc_ready && en_all) |=>
            (dsc_valid && $stable(dsc_id) && $stable(dsc_src_addr)));

    assert_no_read_while_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && dsc_valid));

    assert_end_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chain_end |-> !busy);

    assert_end_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chain_end |=> !chain_end);

    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_start_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en_all) |=> !busy);

    assert_abort_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && !en_all) |=> (!busy && !rd_req));

    assert_tag_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_tag < TAG_W'(MAX_BURST));

endmodule

bind sgdesc_fetch sgf_fetch_chk #(
    .MAX_BURST (MAX_BURST),
    .TAG_W     (TAG_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_enable    (ctl_enable),
    .ctl_sg_enable (ctl_sg_enable),
    .rd_req        (rd_req),
    .rd_addr       (rd_addr),
    .rd_ack        (rd_ack),
    .dsc_valid     (dsc_valid),
    .dsc_ready     (dsc_ready),
    .dsc_id        (dsc_id),
    .dsc_src_addr  (dsc_src_addr),
    .dsc_tag       (dsc_tag),
    .busy          (busy),
    .irq           (irq),
    .chain_end     (chain_end)
);

// File: tb/sgdesc_fetch_tb_top.sv
module sgdesc_fetch_tb_top;

    localparam int unsigned MAX_BURST = 31;
    localparam int unsigned TAG_W     = $clog2(MAX_BURST);
    localparam logic [31:0] HEAD_HI   = 32'h0000_0002;
    localparam logic [31:0] REGION_LO = 32'h0000_1000;

    typedef struct packed {
        logic [31:0] flags;
        logic [31:0] id;
        logic [63:0] dst;
        logic [63:0] src;
        logic [31:0] rows;
        logic [31:0] rowlen;
        logic [31:0] sstr;
        logic [31:0] dstr;
    } vec_t;

    // linear chain: stimulus record and expected decoded fields in one row
    localparam vec_t LIN [4] = '{
        '{32'h0000_0002, 32'h0000_0011, 64'h0000_00AB_1234_5600, 64'h0000_00CD_8765_4300,
          32'd3, 32'd255, 32'd512, 32'd1024},
        '{32'h0000_00F0, 32'h0000_0022, 64'hFEDC_BA98_0000_0040, 64'h0123_4567_89AB_CDE0,
          32'd0, 32'd63, 32'd64, 32'd64},
        '{32'h0000_0002, 32'h0000_0033, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFC0,
          32'hFFFF_FFFF, 32'd1, 32'h0001_0000, 32'h0002_0000},
        '{32'h0000_0003, 32'h0000_0044, 64'h0000_0001_0000_0000, 64'h0000_0002_0000_0000,
          32'd7, 32'd15, 32'd16, 32'd32}
    };

    localparam vec_t CIRC_A = '{32'h0000_0000, 32'h0000_00A0, 64'h1111_0000_2222_0000,
                                64'h3333_0000_4444_0000, 32'd1, 32'd2, 32'd3, 32'd4};
    localparam vec_t CIRC_B = '{32'h0000_0002, 32'h0000_00B0, 64'h5555_0000_6666_0000,
                                64'h7777_0000_8888_0000, 32'd5, 32'd6, 32'd7, 32'd8};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_enable = 1'b0;
    logic ctl_sg_enable = 1'b0;
    logic start = 1'b0;
    logic [31:0] head_addr_lo = '0;
    logic [31:0] head_addr_hi = '0;
    logic rd_req;
    logic [63:0] rd_addr;
    logic rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic dsc_valid;
    logic dsc_ready = 1'b0;
    logic [31:0] dsc_id, dsc_rows, dsc_row_len, dsc_src_stride, dsc_dst_stride;
    logic [63:0] dsc_dst_addr, dsc_src_addr;
    logic [TAG_W-1:0] dsc_tag;
    logic xfer_done = 1'b0;
    logic busy, irq, chain_end;

    always #2.5 clk = ~clk;

    sgdesc_fetch #(.MAX_BURST(MAX_BURST)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_sg_enable(ctl_sg_enable),
        .start(start), .head_addr_lo(head_addr_lo), .head_addr_hi(head_addr_hi),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_id(dsc_id),
        .dsc_dst_addr(dsc_dst_addr), .dsc_src_addr(dsc_src_addr), .dsc_rows(dsc_rows),
        .dsc_row_len(dsc_row_len), .dsc_src_stride(dsc_src_stride),
        .dsc_dst_stride(dsc_dst_stride), .dsc_tag(dsc_tag), .xfer_done(xfer_done),
        .busy(busy), .irq(irq), .chain_end(chain_end)
    );

    logic [31:0] mem_w [256];
    logic [63:0] exp_base = '0;
    int  wcnt = 0;
    int  addr_err = 0;
    bit  mem_slow = 1'b0;
    bit  tgl = 1'b0;
    int  n_checks = 0;
    int  n_fail = 0;

    function automatic logic [63:0] slot_addr(input int s);
        return {HEAD_HI, REGION_LO + 32'(s * 64)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_desc(input int s, input vec_t v, input logic [63:0] nxt);
        int b = 16 * s;
        mem_w[b+0]  = v.flags;       mem_w[b+1]  = v.id;
        mem_w[b+2]  = v.dst[31:0];   mem_w[b+3]  = v.dst[63:32];
        mem_w[b+4]  = v.src[31:0];   mem_w[b+5]  = v.src[63:32];
        mem_w[b+6]  = nxt[31:0];     mem_w[b+7]  = nxt[63:32];
        mem_w[b+8]  = v.rows;        mem_w[b+9]  = v.rowlen;
        mem_w[b+10] = v.sstr;        mem_w[b+11] = v.dstr;
        for (int i = 12; i < 16; i++) mem_w[b+i] = 32'hDEAD_0000 | 32'(i);
    endtask

    // memory responder: grants requests on the negative edge
    initial begin
        forever begin
            @(negedge clk);
            tgl = ~tgl;
            if (rd_req && (!mem_slow || tgl)) begin
                logic [31:0] ofs;
                ofs     = rd_addr[31:0] - REGION_LO;
                rd_ack  = 1'b1;
                rd_data = mem_w[ofs[9:2]];
                if (rd_addr != exp_base + 64'(wcnt * 4)) addr_err++;
                wcnt++;
            end else begin
                rd_ack = 1'b0;
            end
        end
    end

    task automatic kick(input logic [63:0] head);
        @(negedge clk);
        exp_base     = head;
        wcnt         = 0;
        head_addr_lo = head[31:0];
        head_addr_hi = head[63:32];
        start        = 1'b1;
        @(negedge clk);
        start        = 1'b0;
    endtask

    task automatic serve(input vec_t v, input logic [63:0] nxt, input int tag,
                         input bit drop_en);
        int w = 0;
        while (!dsc_valid && w < 400) begin
            @(negedge clk);
            w++;
        end
        chk(dsc_valid, "R4 offer seen", 64'(dsc_valid), 64'd1);
        chk(dsc_id == v.id, "R3 id", 64'(dsc_id), 64'(v.id));
        chk(dsc_dst_addr == v.dst, "R3 dst", dsc_dst_addr, v.dst);
        chk(dsc_src_addr == v.src, "R3 src", dsc_src_addr, v.src);
        chk(dsc_rows == v.rows, "R3 rows", 64'(dsc_rows), 64'(v.rows));
        chk(dsc_row_len == v.rowlen, "R3 rowlen", 64'(dsc_row_len), 64'(v.rowlen));
        chk(dsc_src_stride == v.sstr, "R3 sstride", 64'(dsc_src_stride), 64'(v.sstr));
        chk(dsc_dst_stride == v.dstr, "R3 dstride", 64'(dsc_dst_stride), 64'(v.dstr));
        chk(int'(dsc_tag) == tag, "R11 tag", 64'(dsc_tag), 64'(tag));
        chk(wcnt == 16, "R2 word count", 64'(wcnt), 64'd16);
        chk(addr_err == 0, "R2 R5 R12 address order", 64'(addr_err), 64'd0);
        repeat (2) @(negedge clk);
        chk(dsc_valid && !rd_req, "R4 hold without ready", 64'(dsc_valid), 64'd1);
        dsc_ready = 1'b1;
        @(negedge clk);
        dsc_ready = 1'b0;
        chk(!dsc_valid && !rd_req, "R4 accepted", 64'({dsc_valid, rd_req}), 64'd0);
        repeat (3) @(negedge clk);
        chk(busy && !rd_req, "R4 wait for done", 64'({busy, rd_req}), 64'd2);
        exp_base = nxt;
        wcnt     = 0;
        if (drop_en) ctl_enable = 1'b0;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk(irq == v.flags[1], "R7 irq after done", 64'(irq), 64'(v.flags[1]));
        chk(chain_end == v.flags[0], "R6 end after done", 64'(chain_end), 64'(v.flags[0]));
        if (v.flags[0] || drop_en)
            chk(!busy, "R6 R10 idle after final", 64'(busy), 64'd0);
        @(negedge clk);
        chk(!irq && !chain_end, "R6 R7 single pulse", 64'({irq, chain_end}), 64'd0);
    endtask

    task automatic run_linear(input bit slow);
        mem_slow = slow;
        addr_err = 0;
        kick(slot_addr(0));
        for (int k = 0; k < 4; k++) begin
            serve(LIN[k], slot_addr(k + 1), k, 1'b0);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) put_desc(k, LIN[k], slot_addr(k + 1));
        put_desc(7, CIRC_A, slot_addr(7));
        put_desc(8, CIRC_A, slot_addr(9));
        put_desc(9, CIRC_B, slot_addr(8));

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !rd_req && !dsc_valid && !irq && !chain_end, "R1 reset outputs",
            64'({busy, rd_req, dsc_valid, irq, chain_end}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rd_req, "R1 idle after release", 64'({busy, rd_req}), 64'd0);

        // R9: start ignored with one enable low
        ctl_enable = 1'b1;
        ctl_sg_enable = 1'b0;
        kick(slot_addr(0));
        repeat (4) @(negedge clk);
        chk(!busy && !rd_req, "R9 start ignored sg off", 64'({busy, rd_req}), 64'd0);
        ctl_enable = 1'b0;
        ctl_sg_enable = 1'b1;
        kick(slot_addr(0));
        repeat (4) @(negedge clk);
        chk(!busy && !rd_req, "R9 start ignored enable off", 64'({busy, rd_req}), 64'd0);
        ctl_enable = 1'b1;

        // table walk, fast and slow memory (R2 R3 R4 R5 R6 R7 R11 R12)
        run_linear(1'b0);
        run_linear(1'b1);

        // R10: enable dropped in the cycle the fourth word is granted
        mem_slow = 1'b0;
        kick(slot_addr(0));
        repeat (3) @(negedge clk);
        ctl_sg_enable = 1'b0;
        @(negedge clk);
        chk(!busy && !rd_req, "R10 stop at word boundary", 64'({busy, rd_req}), 64'd0);
        chk(wcnt == 4, "R10 words consumed", 64'(wcnt), 64'd4);
        repeat (20) @(negedge clk);
        chk(!dsc_valid && !busy, "R10 nothing offered", 64'({dsc_valid, busy}), 64'd0);
        ctl_sg_enable = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy, "R9 no restart without start", 64'(busy), 64'd0);

        // R8 R11: circular chain, 33 records, stop via enable on the last
        addr_err = 0;
        kick(slot_addr(8));
        for (int k = 0; k < 33; k++) begin
            serve((k % 2 == 0) ? CIRC_A : CIRC_B,
                  (k % 2 == 0) ? slot_addr(9) : slot_addr(8),
                  k % MAX_BURST, k == 32);
            chk(busy == (k != 32), "R8 chain continues", 64'(busy), 64'(k != 32));
        end
        ctl_enable = 1'b1;

        // restart works after stop
        run_linear(1'b0);

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule